// File: doc/BRIEF.md
# SDRAM Burst Read Cycle Sequencer

This block runs one cache line fill from a synchronous DRAM as a fixed command sequence. A request carries the byte address of the word that missed and selects a 32-bit or 16-bit data bus. The sequencer first opens the row. It then waits a programmable number of RAS-to-CAS cycles. After that it issues one column command per beat.

The column addresses start at the missed word and wrap inside the aligned 16-byte line. Only the low word-select bits step: bits 3:2 on a 32-bit bus and bits 3:1 on a 16-bit bus. The returned data appears a programmable CAS latency later. A bus-start strobe marks every data beat on the bus, and a registered copy of each beat is presented with a valid flag. A programmable precharge interval closes the access. A done pulse marks the last precharge cycle, and the sequencer then returns to idle.

The state machine has six states:

- ST_IDLE: ready, waiting for a request.
- ST_ACT: row activate.
- ST_RCD: RAS-to-CAS wait.
- ST_COL: column cycles.
- ST_LAT: CAS latency drain after the last column.
- ST_PRE: precharge.

The transitions are:

- ST_IDLE→ST_ACT on an accepted request.
- ST_ACT→ST_RCD when the delay setting is non-zero, or ST_ACT→ST_COL when it is zero.
- ST_RCD→ST_COL when the wait count expires.
- ST_COL→ST_LAT after the last beat.
- ST_LAT→ST_PRE after the latency count.
- ST_PRE→ST_IDLE after the precharge count.

Top module: `sdram_burst_rd_seq`

## Requirements
- R1: After reset, sd_cs_n, sd_ras_n and sd_cas_n are high, bus_start, rd_valid and done are low, and req_ready is high.
- R2: A request is taken when req_valid is high in a cycle with req_ready high. In the next cycle sd_ras_n is low, sd_cas_n is high, sd_cs_n is low and sd_addr equals the request address.
- R3: The first column cycle (sd_cas_n low) comes cfg_rcd+1 cycles after the activate cycle, so cfg_rcd wait cycles lie between them.
- R4: With req_half=0 there are four consecutive column cycles. Beat i drives sd_addr = {addr[25:4], (addr[3:2]+i) mod 4, 2'b00}.
- R5: With req_half=1 there are eight consecutive column cycles. Beat i drives sd_addr = {addr[25:4], (addr[3:1]+i) mod 8, 1'b0}.
- R6: Address bits 25:4 on every column cycle equal those of the request. The low bits never carry into them.
- R7: bus_start is high exactly in the cycles that lie CL cycles after a column cycle, one pulse per beat. CL is cfg_cl taken at acceptance (1..3).
- R8: rd_valid is high in the cycle after each bus_start. rd_data then holds sd_dq_in as it stood during that bus_start cycle, and on a 16-bit bus bits 31:16 are zero.
- R9: Precharge starts in the cycle after the last bus_start and lasts max(cfg_tpc,1) cycles. done is high only in its final cycle, and req_ready is high in the following cycle.
- R10: req_valid while busy is ignored, and changes to the request or configuration inputs after acceptance do not alter the running burst.
- R11: sd_cs_n is low from the activate cycle through the final precharge cycle and high otherwise. sd_ras_n is low only in the activate cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request |
| req_addr | input | 26 | Byte address of the missed word |
| req_half | input | 1 | 1 = 16-bit data bus, 0 = 32-bit |
| cfg_rcd | input | 4 | RAS-to-CAS wait cycles |
| cfg_tpc | input | 4 | Precharge cycles (0 acts as 1) |
| cfg_cl | input | 2 | CAS latency 1..3 (0 acts as 1) |
| sd_dq_in | input | 32 | Read data from the DRAM bus |
| req_ready | output | 1 | Idle and able to take a request |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_addr | output | 26 | Row or column address |
| bus_start | output | 1 | Pulse on each data beat on the bus |
| rd_valid | output | 1 | Captured beat valid |
| rd_data | output | 32 | Captured beat |
| done | output | 1 | Final precharge cycle |

## Verification
The registered valid of the last beat falls in the first precharge cycle. With a precharge setting of 0 or 1 it lands in the very cycle that raises done. With a latency of 1, each bus_start also overlaps the next column command. Bursts with zero and one-cycle settings provoke both overlaps. A cycle-accurate reference model in the bench predicts every strobe, address and data value, and each overlapping cycle is judged by comparing all outputs at once.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ACT  = 3'd1,
        ST_RCD  = 3'd2,
        ST_COL  = 3'd3,
        ST_LAT  = 3'd4,
        ST_PRE  = 3'd5
    } sbr_state_e;

    localparam int LINE_BYTES = 16;
    localparam int BEATS_W32  = 4;
    localparam int BEATS_W16  = 8;

endpackage

// File: rtl/sbr_wait_cnt.sv
`timescale 1ns/1ps
module sbr_wait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sbr_colgen.sv
`timescale 1ns/1ps
module sbr_colgen #(
    parameter int ADDR_W = 26
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              half,
    input  logic [2:0]        beat,
    output logic [ADDR_W-1:0] col_addr
);

    logic [1:0] word_idx;
    logic [2:0] half_idx;

    always_comb begin
        word_idx = base[3:2] + beat[1:0];
        half_idx = base[3:1] + beat;
        if (half) begin
            col_addr = {base[ADDR_W-1:4], half_idx, 1'b0};
        end else begin
            col_addr = {base[ADDR_W-1:4], word_idx, 2'b00};
        end
    end

endmodule

// File: rtl/sbr_lat_pipe.sv
`timescale 1ns/1ps
module sbr_lat_pipe #(
    parameter int MAX_CL = 3,
    parameter int DATA_W = 32,
    localparam int CL_W  = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [CL_W-1:0]   lat,
    input  logic              half,
    input  logic [DATA_W-1:0] dq_in,
    output logic              bus_start,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int HALF_W = DATA_W / 2;

    logic [MAX_CL:1] stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[1] <= 1'b0;
        else        stage_q[1] <= issue;
    end

    for (genvar j = 2; j <= MAX_CL; j++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[j] <= 1'b0;
            else        stage_q[j] <= stage_q[j-1];
        end
    end

    always_comb begin
        bus_start = 1'b0;
        for (int k = 1; k <= MAX_CL; k++) begin
            if (lat == CL_W'(k)) bus_start = stage_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= bus_start;
            if (bus_start) begin
                if (half) rd_data <= {{(DATA_W-HALF_W){1'b0}}, dq_in[HALF_W-1:0]};
                else      rd_data <= dq_in;
            end
        end
    end

    AST_VALID_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_start)); // R8

endmodule

// File: rtl/sdram_burst_rd_seq.sv
`timescale 1ns/1ps
module sdram_burst_rd_seq
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4,
    parameter int MAX_CL = 3,
    localparam int CL_W  = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_half,
    input  logic [CNT_W-1:0]  cfg_rcd,
    input  logic [CNT_W-1:0]  cfg_tpc,
    input  logic [CL_W-1:0]   cfg_cl,
    input  logic [DATA_W-1:0] sd_dq_in,
    output logic              req_ready,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              bus_start,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    sbr_state_e state_q, state_nx;

    logic [ADDR_W-1:0] base_q;
    logic              half_q;
    logic [CNT_W-1:0]  rcd_q;
    logic [CNT_W-1:0]  tpc_q;
    logic [CL_W-1:0]   cl_q;
    logic [2:0]        beat_q;
    logic              beat_last;
    logic              accept;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_zero;
    logic              cas_issue;
    logic [ADDR_W-1:0] col_addr;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign beat_last = half_q ? (beat_q == 3'(BEATS_W16 - 1)) : (beat_q == 3'(BEATS_W32 - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // request capture and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            half_q <= 1'b0;
            rcd_q  <= '0;
            tpc_q  <= CNT_W'(1);
            cl_q   <= CL_W'(1);
            beat_q <= '0;
        end else begin
            if (accept) begin
                base_q <= req_addr;
                half_q <= req_half;
                rcd_q  <= cfg_rcd;
                tpc_q  <= (cfg_tpc == '0) ? CNT_W'(1) : cfg_tpc;
                if (cfg_cl == '0)                   cl_q <= CL_W'(1);
                else if (int'(cfg_cl) > MAX_CL)     cl_q <= CL_W'(MAX_CL);
                else                                cl_q <= cfg_cl;
            end
            if (state_q == ST_COL) beat_q <= beat_q + 1'b1;
            else                   beat_q <= '0;
        end
    end

    // next state and wait counter control
    always_comb begin
        state_nx = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_nx = ST_ACT;
            end
            ST_ACT: begin
                if (rcd_q == '0) begin
                    state_nx = ST_COL;
                end else begin
                    state_nx = ST_RCD;
                    cnt_load = 1'b1;
                    cnt_val  = rcd_q - 1'b1;
                end
            end
            ST_RCD: begin
                if (cnt_zero) state_nx = ST_COL;
            end
            ST_COL: begin
                if (beat_last) begin
                    state_nx = ST_LAT;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(cl_q) - 1'b1;
                end
            end
            ST_LAT: begin
                if (cnt_zero) begin
                    state_nx = ST_PRE;
                    cnt_load = 1'b1;
                    cnt_val  = tpc_q - 1'b1;
                end
            end
            ST_PRE: begin
                if (cnt_zero) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        sd_cs_n   = 1'b0;
        sd_ras_n  = 1'b1;
        cas_issue = 1'b0;
        sd_addr   = base_q;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                sd_cs_n   = 1'b1;
            end
            ST_ACT: begin
                sd_ras_n = 1'b0;
            end
            ST_RCD: begin
            end
            ST_COL: begin
                cas_issue = 1'b1;
                sd_addr   = col_addr;
            end
            ST_LAT: begin
            end
            ST_PRE: begin
                done = cnt_zero;
            end
            default: begin
                sd_cs_n = 1'b1;
            end
        endcase
    end

    assign sd_cas_n = ~cas_issue;

    sbr_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sbr_colgen #(.ADDR_W(ADDR_W)) u_col (
        .base     (base_q),
        .half     (half_q),
        .beat     (beat_q),
        .col_addr (col_addr)
    );

    sbr_lat_pipe #(.MAX_CL(MAX_CL), .DATA_W(DATA_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (cas_issue),
        .lat       (cl_q),
        .half      (half_q),
        .dq_in     (sd_dq_in),
        .bus_start (bus_start),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    AST_ACT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (!sd_ras_n && sd_cas_n && !sd_cs_n)); // R2
    AST_RAS_CAS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_ras_n |-> sd_cas_n); // R11
    AST_CMD_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_ras_n || !sd_cas_n) |-> !sd_cs_n); // R11
    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cas_n && $past(!sd_cas_n)) |-> (sd_addr[ADDR_W-1:4] == $past(sd_addr[ADDR_W-1:4]))); // R6
    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready); // R9

endmodule

// File: tb/sim_sdram_burst_rd_seq.sv
`timescale 1ns/1ps
module sim_sdram_burst_rd_seq;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] JUNK = 32'h0BAD_F00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [25:0] req_addr = '0;
    logic        req_half = 1'b0;
    logic [3:0]  cfg_rcd = '0;
    logic [3:0]  cfg_tpc = '0;
    logic [1:0]  cfg_cl = 2'd1;
    logic [31:0] sd_dq_in = JUNK;
    logic        req_ready, sd_cs_n, sd_ras_n, sd_cas_n, bus_start, rd_valid, done;
    logic [25:0] sd_addr;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    int n_acc = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_rd_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_half(req_half), .cfg_rcd(cfg_rcd), .cfg_tpc(cfg_tpc), .cfg_cl(cfg_cl),
        .sd_dq_in(sd_dq_in), .req_ready(req_ready), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_addr(sd_addr),
        .bus_start(bus_start), .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input logic [25:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0] ^ 16'h1E0F};
    endfunction

    function automatic logic [25:0] beat_addr(input logic [25:0] b, input bit h, input int i);
        logic [1:0] w;
        logic [2:0] hw;
        w  = b[3:2] + 2'(i);
        hw = b[3:1] + 3'(i);
        return h ? {b[25:4], hw, 1'b0} : {b[25:4], w, 2'b00};
    endfunction

    // reference model state
    bit          m_busy = 0;
    int          m_acc, m_rcd, m_tp, m_cl, m_nb;
    bit          m_half;
    logic [25:0] m_base;
    logic [25:0] devq [int];

    always @(negedge clk) begin
        int rel, c0, pend, bi;
        bit e_ras, e_cas, e_bs, e_rv, e_done, e_cs, e_rdy;
        logic [25:0] e_addr;
        logic [31:0] e_data;
        if (rst_n) begin
            cyc++;
            if (cyc > 20000) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
            rel = cyc - m_acc;
            c0 = 2 + m_rcd;
            pend = 1 + m_rcd + m_nb + m_cl + m_tp;
            if (m_busy && rel == pend + 1) m_busy = 0;
            e_ras = 0; e_cas = 0; e_bs = 0; e_rv = 0; e_done = 0;
            e_cs = m_busy; e_rdy = !m_busy; e_addr = m_base; e_data = '0;
            if (m_busy) begin
                e_ras = (rel == 1);
                e_cas = (rel >= c0) && (rel < c0 + m_nb);
                if (e_cas) e_addr = beat_addr(m_base, m_half, rel - c0);
                e_bs = (rel - m_cl >= c0) && (rel - m_cl < c0 + m_nb);
                bi = rel - m_cl - 1 - c0;
                e_rv = (bi >= 0) && (bi < m_nb);
                if (e_rv) begin
                    e_data = pat(beat_addr(m_base, m_half, bi));
                    if (m_half) e_data[31:16] = '0;
                end
                e_done = (rel == pend);
            end
            chk(req_ready == e_rdy, "R10", "req_ready", req_ready, e_rdy);
            chk(sd_cs_n == !e_cs, "R11", "sd_cs_n", sd_cs_n, !e_cs);
            chk(sd_ras_n == !e_ras, (m_busy && rel == 1) ? "R2" : "R11", "sd_ras_n", sd_ras_n, !e_ras);
            chk(sd_cas_n == !e_cas, "R3", "sd_cas_n", sd_cas_n, !e_cas);
            if (e_ras || e_cas) begin
                chk(sd_addr[25:4] == e_addr[25:4], "R6", "sd_addr upper", sd_addr[25:4], e_addr[25:4]);
                chk(sd_addr[3:0] == e_addr[3:0], e_ras ? "R2" : (m_half ? "R5" : "R4"),
                    "sd_addr low", sd_addr[3:0], e_addr[3:0]);
            end
            chk(bus_start == e_bs, "R7", "bus_start", bus_start, e_bs);
            chk(rd_valid == e_rv, "R8", "rd_valid", rd_valid, e_rv);
            if (e_rv) chk(rd_data == e_data, "R8", "rd_data", rd_data, e_data);
            chk(done == e_done, "R9", "done", done, e_done);
            // DRAM bus model
            if (sd_cas_n == 1'b0) devq[cyc + m_cl] = sd_addr;
            sd_dq_in = devq.exists(cyc) ? pat(devq[cyc]) : JUNK;
            // acceptance
            if (!m_busy && req_valid) begin
                m_busy = 1; m_acc = cyc; m_base = req_addr; m_half = req_half;
                m_rcd = int'(cfg_rcd);
                m_tp = (cfg_tpc == 0) ? 1 : int'(cfg_tpc);
                m_cl = (cfg_cl == 0) ? 1 : int'(cfg_cl);
                m_nb = req_half ? 8 : 4;
                n_acc++;
            end
        end
    end

    task automatic burst(input logic [25:0] a, input bit h, input int rcd, input int tpc, input int cl);
        int n0;
        n0 = n_acc;
        req_addr = a; req_half = h; cfg_rcd = 4'(rcd); cfg_tpc = 4'(tpc); cfg_cl = 2'(cl);
        req_valid = 1;
        wait (n_acc != n0);
        @(posedge clk); #1;
        // R10: scramble inputs and hold a spurious request while busy
        req_addr = ~a; req_half = ~h; cfg_rcd = 4'(rcd + 5); cfg_tpc = 4'(tpc + 6);
        cfg_cl = 2'((cl % 3) + 1);
        repeat (4) @(posedge clk);
        #1 req_valid = 0;
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            // R1: idle outputs under reset
            chk(sd_cs_n && sd_ras_n && sd_cas_n, "R1", "strobes in reset", {sd_cs_n, sd_ras_n, sd_cas_n}, 3'b111);
            chk(!bus_start && !rd_valid && !done, "R1", "pulses in reset", {bus_start, rd_valid, done}, 3'b000);
            chk(req_ready, "R1", "req_ready in reset", req_ready, 1);
        end
        @(posedge clk); #1 rst_n = 1;
        burst(26'h0123458, 0, 1, 1, 2);
        burst(26'h3ABCDEC, 0, 0, 0, 1);
        burst(26'h0000006, 1, 2, 3, 3);
        burst(26'h1FFFFFE, 1, 1, 1, 2);
        burst(26'h2345670, 0, 3, 2, 3);
        burst(26'h0F0F0F0, 1, 0, 1, 1);
        burst(26'h155555C, 0, 0, 1, 3);
        wait (!m_busy);
        repeat (10) @(posedge clk);
        @(negedge clk); #1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule